// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of a small byte-oriented processor and works out its next value each time the instruction sequencer issues a step. The sequencer supplies an operation class, the instruction length and the operand fields the instruction carries: a signed 8-bit displacement, an 11-bit in-page address, a full 16-bit target, the accumulator, the 16-bit data pointer and a return address that has been read back from the stack. The block applies the rule for that class and registers the result on the step strobe.

Every target that depends on the program counter is formed from the address of the following instruction, not from the opcode address. This covers the relative displacement, the replacement of the low 11 bits inside a 2 KB page, and the return address handed out for saving on calls. The stack storage itself, opcode decoding and the memory fetch sit in neighbouring blocks.

Top module: `pc_next_unit`

## Requirements
- R1: After reset the program counter reads 0000H, and every addition in the block wraps modulo 65536.
- R2: Operation class 0 (sequential) loads PC + length, where the 2-bit length input carries 1, 2 or 3.
- R3: Operation class 1 (short relative jump) loads PC + 2 + the sign-extended 8-bit displacement.
- R4: Operation classes 2 (page jump) and 3 (page call) load a value whose bits 15..11 come from PC + 2 and whose bits 10..0 are the 11-bit page address.
- R5: Operation classes 4 (long jump) and 5 (long call) load the 16-bit target unchanged.
- R6: Operation class 6 (indirect jump) loads the zero-extended 8-bit accumulator plus the 16-bit data pointer.
- R7: The return-address output shows PC + 2 while class 3 is presented, PC + 3 while class 5 is presented, and PC + length for every other class, taken from the current PC before the step.
- R8: Operation class 7 (return) loads the restored return address input.
- R9: Without the step strobe the program counter keeps its value whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance the program counter at this edge |
| op_i | input | 3 | Operation class, encoding as in R2 to R8 |
| len_i | input | 2 | Instruction length in bytes |
| rel_ofs_i | input | 8 | Signed relative displacement |
| page_addr_i | input | 11 | In-page address for page jumps and calls |
| abs_tgt_i | input | 16 | Absolute target for long jumps and calls |
| acc_i | input | 8 | Accumulator value for indirect jumps |
| dptr_i | input | 16 | Data pointer value for indirect jumps |
| ret_in_i | input | 16 | Return address restored from the stack |
| pc_o | output | 16 | Current program counter |
| ret_addr_o | output | 16 | Return address to be saved by a call |

## Verification
The bench builds the block with its default widths: a 16-bit counter, an 8-bit displacement and accumulator, and an 11-bit page field. These sizes keep full sweeps short: all 256 displacements from several starting addresses, all 2048 page addresses for both page classes, and all 256 accumulator values over several data pointers. The starting points include addresses where PC + 2 crosses into the next page or wraps past FFFFH, so wrap-around and page selection from the following instruction are both exercised.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [2:0] {
        OPC_SEQ       = 3'd0,
        OPC_REL       = 3'd1,
        OPC_PAGE_JMP  = 3'd2,
        OPC_PAGE_CALL = 3'd3,
        OPC_LONG_JMP  = 3'd4,
        OPC_LONG_CALL = 3'd5,
        OPC_INDIRECT  = 3'd6,
        OPC_RETURN    = 3'd7
    } op_class_e;

endpackage

// File: rtl/pc_adder_bank.sv
module pc_adder_bank #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] plus_len_o,
    output logic [ADDR_W-1:0] plus2_o,
    output logic [ADDR_W-1:0] plus3_o
);
    localparam int PAD_W = ADDR_W - LEN_W;

    always_comb begin
        plus_len_o = pc_i + {{PAD_W{1'b0}}, len_i};
        plus2_o    = pc_i + ADDR_W'(2);
        plus3_o    = pc_i + ADDR_W'(3);
    end

endmodule

// File: rtl/pc_target_mux.sv
module pc_target_mux
    import pc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    parameter int PAGE_W = 11,
    parameter int ACC_W  = 8
) (
    input  op_class_e         op_i,
    input  logic [ADDR_W-1:0] plus_len_i,
    input  logic [ADDR_W-1:0] plus2_i,
    input  logic [ADDR_W-1:0] plus3_i,
    input  logic [OFS_W-1:0]  rel_ofs_i,
    input  logic [PAGE_W-1:0] page_addr_i,
    input  logic [ADDR_W-1:0] abs_tgt_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [ADDR_W-1:0] dptr_i,
    input  logic [ADDR_W-1:0] ret_in_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [ADDR_W-1:0] ret_addr_o
);
    localparam int SEXT_W = ADDR_W - OFS_W;
    localparam int ZEXT_W = ADDR_W - ACC_W;
    localparam int HIGH_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] page_tgt;
    logic [ADDR_W-1:0] ind_tgt;

    always_comb begin
        rel_tgt  = plus2_i + {{SEXT_W{rel_ofs_i[OFS_W-1]}}, rel_ofs_i};
        page_tgt = {plus2_i[ADDR_W-1 -: HIGH_W], page_addr_i};
        ind_tgt  = dptr_i + {{ZEXT_W{1'b0}}, acc_i};

        unique case (op_i)
            OPC_SEQ:                     next_pc_o = plus_len_i;
            OPC_REL:                     next_pc_o = rel_tgt;
            OPC_PAGE_JMP, OPC_PAGE_CALL: next_pc_o = page_tgt;
            OPC_LONG_JMP, OPC_LONG_CALL: next_pc_o = abs_tgt_i;
            OPC_INDIRECT:                next_pc_o = ind_tgt;
            OPC_RETURN:                  next_pc_o = ret_in_i;
            default:                     next_pc_o = plus_len_i;
        endcase

        unique case (op_i)
            OPC_PAGE_CALL: ret_addr_o = plus2_i;
            OPC_LONG_CALL: ret_addr_o = plus3_i;
            default:       ret_addr_o = plus_len_i;
        endcase
    end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2,
    parameter int OFS_W  = 8,
    parameter int PAGE_W = 11,
    parameter int ACC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [2:0]        op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [OFS_W-1:0]  rel_ofs_i,
    input  logic [PAGE_W-1:0] page_addr_i,
    input  logic [ADDR_W-1:0] abs_tgt_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [ADDR_W-1:0] dptr_i,
    input  logic [ADDR_W-1:0] ret_in_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] ret_addr_o
);
    localparam int HIGH_W = ADDR_W - PAGE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t state_d, state_q;
    op_class_e op_cls;
    logic [ADDR_W-1:0] plus_len, plus2, plus3, next_pc;

    assign op_cls = op_class_e'(op_i);

    pc_adder_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) adders_i (
        .pc_i       (state_q.pc),
        .len_i      (len_i),
        .plus_len_o (plus_len),
        .plus2_o    (plus2),
        .plus3_o    (plus3)
    );

    pc_target_mux #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .ACC_W(ACC_W)
    ) mux_i (
        .op_i        (op_cls),
        .plus_len_i  (plus_len),
        .plus2_i     (plus2),
        .plus3_i     (plus3),
        .rel_ofs_i   (rel_ofs_i),
        .page_addr_i (page_addr_i),
        .abs_tgt_i   (abs_tgt_i),
        .acc_i       (acc_i),
        .dptr_i      (dptr_i),
        .ret_in_i    (ret_in_i),
        .next_pc_o   (next_pc),
        .ret_addr_o  (ret_addr_o)
    );

    always_comb begin
        state_d = state_q;
        if (step_i) begin
            state_d.pc = next_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o = state_q.pc;

    // Guards on the registered counter against the operands of the previous step
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> pc_o == $past(pc_o));

    assert_seq_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && op_cls == OPC_SEQ) |=>
            (pc_o - $past(pc_o)) == ADDR_W'($past(len_i)));

    assert_page_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (op_cls == OPC_PAGE_JMP || op_cls == OPC_PAGE_CALL)) |=>
            (pc_o[PAGE_W-1:0] == $past(page_addr_i) &&
             pc_o[ADDR_W-1 -: HIGH_W] == $past(plus2[ADDR_W-1 -: HIGH_W])));

    assert_long_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (op_cls == OPC_LONG_JMP || op_cls == OPC_LONG_CALL)) |=>
            pc_o == $past(abs_tgt_i));

    assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && op_cls == OPC_RETURN) |=> pc_o == $past(ret_in_i));

    assert_call_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cls == OPC_LONG_CALL) |-> (ret_addr_o - pc_o) == ADDR_W'(3));

endmodule

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [1:0]  len_i = 2'd1;
    logic [7:0]  rel_ofs_i = '0;
    logic [10:0] page_addr_i = '0;
    logic [15:0] abs_tgt_i = '0;
    logic [7:0]  acc_i = '0;
    logic [15:0] dptr_i = '0;
    logic [15:0] ret_in_i = '0;
    logic [15:0] pc_o, ret_addr_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_next_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i), .len_i(len_i),
        .rel_ofs_i(rel_ofs_i), .page_addr_i(page_addr_i), .abs_tgt_i(abs_tgt_i),
        .acc_i(acc_i), .dptr_i(dptr_i), .ret_in_i(ret_in_i),
        .pc_o(pc_o), .ret_addr_o(ret_addr_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %04h expected %04h", req, got, exp);
        end
    endtask

    // Drive one step with the given class; ends at a falling edge after the update
    task automatic do_step(input logic [2:0] op);
        @(negedge clk);
        op_i = op;
        step_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic load_pc(input logic [15:0] v);
        abs_tgt_i = v;
        do_step(3'd4);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] starts [4];
        logic [15:0] dps [3];
        logic [15:0] exp, base;
        starts[0] = 16'h0000; starts[1] = 16'h0123;
        starts[2] = 16'hFFFE; starts[3] = 16'h7FF0;
        dps[0] = 16'h0000; dps[1] = 16'hFF80; dps[2] = 16'h1234;

        repeat (3) @(negedge clk);
        check("R1 reset value", pc_o, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 value after release", pc_o, 16'h0000);

        // R9: no step, noisy operands
        abs_tgt_i = 16'hBEEF; ret_in_i = 16'h5555; op_i = 3'd4;
        repeat (4) @(negedge clk);
        check("R9 hold with long jump presented", pc_o, 16'h0000);
        op_i = 3'd7;
        repeat (3) @(negedge clk);
        check("R9 hold with return presented", pc_o, 16'h0000);

        // R2 sequential, including wrap for R1
        for (int s = 0; s < 4; s++) begin
            for (int l = 1; l <= 3; l++) begin
                load_pc(starts[s]);
                len_i = 2'(l);
                do_step(3'd0);
                check("R2 sequential advance", pc_o, 16'(starts[s] + 16'(l)));
            end
        end
        load_pc(16'hFFFF);
        len_i = 2'd2;
        do_step(3'd0);
        check("R1 wrap past FFFF", pc_o, 16'h0001);

        // R3 all displacements
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 256; o++) begin
                load_pc(starts[s]);
                rel_ofs_i = 8'(o);
                do_step(3'd1);
                exp = 16'(starts[s] + 16'd2 + 16'(signed'(8'(o))));
                check("R3 relative jump", pc_o, exp);
            end
        end

        // R4 every page address, both page classes, page crossing and wrap
        for (int s = 0; s < 3; s++) begin
            base = (s == 0) ? 16'h07FE : (s == 1) ? 16'hFFFE : 16'h4A10;
            for (int c = 2; c <= 3; c++) begin
                for (int p = 0; p < 2048; p += ((s == 2) ? 37 : 1)) begin
                    load_pc(base);
                    page_addr_i = 11'(p);
                    do_step(3'(c));
                    exp = {16'(base + 16'd2) >> 11, 11'(p)} ;
                    exp = {exp[15:11], 11'(p)};
                    check("R4 page target", pc_o, {16'(base + 16'd2) & 16'hF800} | 16'(p));
                end
            end
        end

        // R5 long loads
        for (int k = 0; k < 16; k++) begin
            abs_tgt_i = 16'(k * 16'h1111 + 16'h0F0F);
            do_step((k % 2 == 0) ? 3'd4 : 3'd5);
            check("R5 long target", pc_o, 16'(k * 16'h1111 + 16'h0F0F));
        end

        // R6 indirect: every accumulator value
        for (int d = 0; d < 3; d++) begin
            for (int a = 0; a < 256; a++) begin
                acc_i = 8'(a);
                dptr_i = dps[d];
                do_step(3'd6);
                check("R6 indirect target", pc_o, 16'(dps[d] + 16'(a)));
            end
        end

        // R7 return address before the step, then R8 return
        load_pc(16'h0123);
        op_i = 3'd5; abs_tgt_i = 16'h2000;
        #1;
        check("R7 long call return address", ret_addr_o, 16'h0126);
        op_i = 3'd3; len_i = 2'd3;
        #1;
        check("R7 page call return address", ret_addr_o, 16'h0125);
        op_i = 3'd0; len_i = 2'd1;
        #1;
        check("R7 other class return address", ret_addr_o, 16'h0124);
        load_pc(16'hFFFE);
        op_i = 3'd5;
        #1;
        check("R7 long call wrap", ret_addr_o, 16'h0001);
        op_i = 3'd3;
        #1;
        check("R7 page call wrap", ret_addr_o, 16'h0000);

        load_pc(16'h0123);
        abs_tgt_i = 16'h2000;
        do_step(3'd5);
        check("R5 call enters subroutine", pc_o, 16'h2000);
        ret_in_i = 16'h0126;
        do_step(3'd7);
        check("R8 return resumes after call", pc_o, 16'h0126);
        ret_in_i = 16'hFFFF;
        do_step(3'd7);
        check("R8 return to top address", pc_o, 16'hFFFF);

        // R9 again from a nonzero value
        step_i = 1'b0; op_i = 3'd6; acc_i = 8'h10; dptr_i = 16'h0100;
        repeat (5) @(negedge clk);
        check("R9 hold with indirect presented", pc_o, 16'hFFFF);

        finish_run();
    end

endmodule